// File: doc/BRIEF.md
# Priority-Encoded Magnitude Comparator

This block compares two unsigned operands of the same width and reports whether the first is greater than, less than or equal to the second. The inputs and outputs have no clock and no registers between them. The block forms the bitwise difference of the operands. It keeps only the most significant differing bit, with a priority selection inside each 4-bit slice. It then checks which operand holds a one at that position.

The slices are chained from the most significant one downward through an enable signal. Any slice that sees a difference withdraws the enable from every slice below it, so only one slice can ever report a decision. The operand width is a parameter and must be a multiple of four. The equality flag comes from a separate NOR reduction of the difference vector, which runs beside the slice chain and not through it.

Top module: `mag_cmp_prio`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i` in every bit.
- R2: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, with both read as unsigned binary numbers (bit 0 least significant).
- R3: `lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned numbers.
- R4: Only the most significant bit position where the operands differ decides the result. Bits below it have no effect on `gt_o` or `lt_o`. For example, 0x8000 against 0x7FFF gives `gt_o`=1.
- R5: A slice that holds a difference silences every less significant slice. This holds even when the lower slices hold differences of the opposite direction. For example, 0x1000 against 0x0FFF gives `gt_o`=1, and 0x0F00 against 0x10FF gives `lt_o`=1.
- R6: Exactly one of `gt_o`, `lt_o` and `eq_o` is 1 for every input pair.
- R7: The `WIDTH` parameter selects the operand width. Any multiple of four builds a chain of `WIDTH/4` slices that behaves as in R1 to R3 at that width.
- R8: At a width of four, `a_i`=4'b1011 and `b_i`=4'b1000 give `gt_o`=1, `lt_o`=0 and `eq_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |
| lt_o | output | 1 | High when a_i < b_i |
| eq_o | output | 1 | High when a_i == b_i |

## Verification
Whenever the logic settles, the assertions check several properties. The priority selection inside each slice marks at most one bit. A slice never raises both of its flags. A slice without the enable stays silent, and the three top outputs are always mutually exclusive. The assertions cannot show that the flags are correct. That comes only from the bench scenarios: an exhaustive sweep at 8 bits, random and hand-picked 16-bit pairs whose lower slices differ in the opposite direction, and the 4-bit worked case, all checked against arithmetic comparison.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  // Width of one priority slice; the chain is built from these.
  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SW = SLICE_W
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          en_i,
  output logic          en_o,
  output cmp_flags_t    flags_o
);
  logic [SW-1:0] diff;
  logic [SW-1:0] sel;
  logic [SW-1:0] gt_terms;
  logic [SW-1:0] lt_terms;

  // Priority pick: a bit survives only when no higher bit differs.
  always_comb begin
    logic above;
    diff  = a_i ^ b_i;
    above = 1'b0;
    for (int k = SW - 1; k >= 0; k--) begin
      sel[k] = diff[k] & ~above & en_i;
      above  = above | diff[k];
    end
    gt_terms   = a_i & sel;
    lt_terms   = b_i & sel;
    flags_o.gt = |gt_terms;
    flags_o.lt = |lt_terms;
    en_o       = en_i & ~(|diff);

    AST_ONEHOT_PICK: assert ($onehot0(sel)) else $error("slice selected several bits"); // R4
    AST_SLICE_EXCL: assert (!(flags_o.gt && flags_o.lt)) else $error("slice raised both flags"); // R6
    AST_SILENCED: assert (en_i || (!flags_o.gt && !flags_o.lt)) else $error("disabled slice drove a flag"); // R5
    AST_PASS_ON: assert (!en_o || (gt_terms == '0 && lt_terms == '0)) else $error("enable passed past a decision"); // R5
  end
endmodule

// File: rtl/mag_cmp_eq.sv
module mag_cmp_eq #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] mismatch;

  always_comb begin
    mismatch = a_i ^ b_i;
    eq_o     = ~(|mismatch);
  end
endmodule

// File: rtl/mag_cmp_prio.sv
module mag_cmp_prio
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  generate
    if ((WIDTH % SLICE_W) != 0 || WIDTH == 0) begin : g_bad_width
      $error("WIDTH must be a nonzero multiple of the slice width");
    end
  endgenerate

  // en_chain[NSLICE] feeds the top slice; each slice passes its enable down.
  logic [NSLICE:0]   en_chain;
  cmp_flags_t        flags [NSLICE];
  logic [NSLICE-1:0] gt_vec;
  logic [NSLICE-1:0] lt_vec;
  logic              eq_w;

  assign en_chain[NSLICE] = 1'b1;

  generate
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      mag_cmp_slice #(.SW(SLICE_W)) i_slice (
        .a_i    (a_i[s*SLICE_W +: SLICE_W]),
        .b_i    (b_i[s*SLICE_W +: SLICE_W]),
        .en_i   (en_chain[s+1]),
        .en_o   (en_chain[s]),
        .flags_o(flags[s])
      );
      assign gt_vec[s] = flags[s].gt;
      assign lt_vec[s] = flags[s].lt;
    end
  endgenerate

  mag_cmp_eq #(.W(WIDTH)) i_eq (
    .a_i (a_i),
    .b_i (b_i),
    .eq_o(eq_w)
  );

  always_comb begin
    gt_o = |gt_vec;
    lt_o = |lt_vec;
    eq_o = eq_w;
  end

  always_comb begin
    AST_ONE_DECIDER: assert ($countones({gt_vec, lt_vec}) <= 1) else $error("several slices decided"); // R5
    AST_ONE_RESULT: assert ($countones({gt_o, lt_o, eq_o}) == 1) else $error("outputs not exclusive"); // R6
    AST_EQ_CHAIN: assert (eq_w == en_chain[0]) else $error("equality and chain disagree"); // R1
  end
endmodule

// File: tb/test_mag_cmp_prio.sv
module test_mag_cmp_prio;
  logic clk;
  logic rst_n;
  int   total;
  int   bad;
  bit   done;

  logic [15:0] a16, b16;
  logic        gt16, lt16, eq16;
  logic [7:0]  a8, b8;
  logic        gt8, lt8, eq8;
  logic [3:0]  a4, b4;
  logic        gt4, lt4, eq4;

  mag_cmp_prio #(.WIDTH(16)) i_mag_cmp_prio (
    .a_i(a16), .b_i(b16), .gt_o(gt16), .lt_o(lt16), .eq_o(eq16)
  );
  mag_cmp_prio #(.WIDTH(8)) i_mag_cmp_prio_w8 (
    .a_i(a8), .b_i(b8), .gt_o(gt8), .lt_o(lt8), .eq_o(eq8)
  );
  mag_cmp_prio #(.WIDTH(4)) i_mag_cmp_prio_w4 (
    .a_i(a4), .b_i(b4), .gt_o(gt4), .lt_o(lt4), .eq_o(eq4)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got gt/lt/eq=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b, input string tag);
    @(negedge clk);
    a16 = a;
    b16 = b;
    #1;
    chk(tag, {gt16, lt16, eq16}, {a > b, a < b, a == b});
  endtask

  initial begin
    rst_n = 1'b0;
    total = 0;
    bad   = 0;
    done  = 1'b0;
    a16 = '0; b16 = '0; a8 = '0; b8 = '0; a4 = '0; b4 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Initial all-zero operands: equal
    chk("R1 zero operands", {gt16, lt16, eq16}, 3'b001);

    // R8: worked 4-bit case
    @(negedge clk);
    a4 = 4'b1011; b4 = 4'b1000;
    #1;
    chk("R8 1011 vs 1000", {gt4, lt4, eq4}, 3'b100);

    // R4 / R5 directed cases with opposite-direction lower differences
    run16(16'h8000, 16'h7FFF, "R4 msb beats all lower");
    run16(16'h7FFF, 16'h8000, "R4 msb lost");
    run16(16'h1000, 16'h0FFF, "R5 slice 3 silences lower");
    run16(16'h0F00, 16'h10FF, "R5 upper slice wins lt");
    run16(16'h00F1, 16'h00EF, "R5 slice 1 over slice 0");
    run16(16'h0001, 16'h0000, "R2 lsb only");
    run16(16'h0000, 16'h0001, "R3 lsb only");
    run16(16'hFFFF, 16'hFFFF, "R1 all ones");
    run16(16'hA5A5, 16'hA5A5, "R1 pattern equal");
    run16(16'h0123, 16'h0122, "R2 within lowest slice");

    // R7 / R6: exhaustive sweep at 8 bits
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a8 = i[7:0];
        b8 = j[7:0];
        #1;
        chk("R7 R6 8-bit sweep", {gt8, lt8, eq8}, {i > j, i < j, i == j});
      end
    end

    // R2 R3 R1: random 16-bit pairs, many sharing upper bits
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (n % 3 == 0) rb[15:8] = ra[15:8];
      if (n % 7 == 0) rb = ra;
      run16(ra, rb, "R2 R3 R1 random 16-bit");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule